// File: doc/BRIEF.md
# Stepped-Phase Sine/Cosine Aspect Generator

This block supplies the trigonometric factors for a transform that folds each arriving sample into every coefficient as soon as the sample is available. For one sample, the coefficient loop visits indices 0, 1, 2 and so on. For coefficient k, the block must give the phase k·s mod 64 together with the sine and cosine of that phase, where s is the current sample number. It does this without a multiplier. A 6-bit accumulator is loaded with zero and latches the sample number as its step at the start of each sweep. Each advance then adds the step once. The two top phase bits select a quadrant. The four low bits address a 17-entry quarter-wave table, and that address is mirrored in the second and fourth quadrants. The quadrant also gives the sign of each path. Unity is scaled to 128.

The control is a two-state machine. `ST_WAIT` is the state after reset, before any sweep has begun. `ST_SWEEP` is the state in which advances produce aspects. There are two transitions. The first is WAIT→SWEEP, taken when `restart` is asserted. The second is SWEEP→SWEEP, taken on a `restart` that arrives during a sweep. It reloads the phase and the step. No transition returns to WAIT except reset.

Top module: `stepped_aspect_gen`

## Requirements
- R1: After reset, `phase_o`, both magnitudes and both signs are 0.
- R2: A `restart` clears the phase accumulator to 0 and latches `step_num` as the step. The first advance that follows emits phase 0.
- R3: The k-th advance after a restart (k = 0, 1, …) emits `phase_o` = k·step mod 64 on the cycle after the advance is sampled.
- R4: In `ST_WAIT`, an `advance` without `restart` has no effect: all outputs keep their reset values.
- R5: On a cycle without `advance`, all outputs hold their previous values.
- R6: `sin_mag_o` = round(128·|sin(2π·p/64)|) for emitted phase p. The table index is the offset p[3:0] in quadrants 0 and 2, and 16 − offset in quadrants 1 and 3.
- R7: `cos_mag_o` = round(128·|cos(2π·p/64)|). The table index is 16 − offset in quadrants 0 and 2, and the offset itself in quadrants 1 and 3.
- R8: The quadrant is p[5:4]. `cos_neg_o` is 1 in quadrants 1 and 2. `sin_neg_o` is 1 in quadrants 2 and 3.
- R9: At phases 0 and 32 the cosine magnitude is exactly 128 and the sine magnitude is exactly 0. The cosine is negative only at phase 32.
- R10: No magnitude ever exceeds 128.
- R11: When `restart` and `advance` are sampled on the same cycle, phase 0 is emitted and the next advance emits the new step.
- R12: A `restart` in the middle of a sweep discards the old phase and step. The following advances use the new `step_num`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| step_num | input | 6 | Sample number, latched as the phase step on restart |
| restart | input | 1 | Starts a coefficient sweep |
| advance | input | 1 | Emits the aspect for the current coefficient, then steps the phase |
| phase_o | output | 6 | Phase of the emitted aspect |
| cos_mag_o | output | 8 | Cosine magnitude, 128 = 1.0 |
| cos_neg_o | output | 1 | Cosine is negative |
| sin_mag_o | output | 8 | Sine magnitude, 128 = 1.0 |
| sin_neg_o | output | 1 | Sine is negative |

## Verification
Every result is due exactly one cycle after the `advance` that requests it, because the emitted phase, the magnitudes and the signs all pass through a single output register. The bench changes the inputs on the falling edge. It updates its reference model at the next rising edge and compares all five outputs on the falling edge that follows. Each comparison therefore falls one cycle after its stimulus. Cycles without an advance are compared against the previously expected values, which checks that the outputs hold.

// File: rtl/aspect_pkg.sv
package aspect_pkg;
    localparam int PH_W  = 6;
    localparam int OFS_W = PH_W - 2;
    localparam int QTR   = 1 << OFS_W;
    localparam int IDX_W = OFS_W + 1;
    localparam int MAG_W = 8;
    localparam int UNITY = 128;

    typedef enum logic {ST_WAIT, ST_SWEEP} sweep_st_t;
    typedef logic [PH_W-1:0]  phase_t;
    typedef logic [IDX_W-1:0] qidx_t;
    typedef logic [MAG_W-1:0] mag_t;
endpackage

// File: rtl/sweep_phase_fsm.sv
module sweep_phase_fsm
    import aspect_pkg::*;
(
    input  logic   clk,
    input  logic   rst_n,
    input  logic   restart,
    input  logic   advance,
    input  phase_t step_num,
    output logic   emit,
    output phase_t cur_phase
);
    sweep_st_t state_q, state_d;
    phase_t    acc_q, step_q;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_WAIT;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_WAIT:  if (restart) state_d = ST_SWEEP;
            ST_SWEEP: state_d = ST_SWEEP;
            default:  state_d = ST_WAIT;
        endcase
    end

    always_comb begin
        emit      = advance && (restart || state_q == ST_SWEEP);
        cur_phase = restart ? '0 : acc_q;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            step_q <= '0;
        end else if (restart) begin
            step_q <= step_num;
            acc_q  <= advance ? step_num : '0;
        end else if (emit) begin
            acc_q  <= acc_q + step_q;
        end
    end

    assert_restart_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && !advance) |=> (acc_q == '0));
    assert_wait_silent_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_WAIT && !restart) |-> !emit);
    assert_sweep_sticky_R12: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_SWEEP) |=> (state_q == ST_SWEEP));
endmodule

// File: rtl/quadrant_fold.sv
module quadrant_fold
    import aspect_pkg::*;
(
    input  phase_t phase,
    output qidx_t  sin_idx,
    output qidx_t  cos_idx,
    output logic   sin_neg,
    output logic   cos_neg
);
    logic [1:0] quad;
    qidx_t      ofs, mirr;

    always_comb begin
        quad    = phase[PH_W-1 -: 2];
        ofs     = {1'b0, phase[OFS_W-1:0]};
        mirr    = IDX_W'(QTR) - ofs;
        sin_idx = quad[0] ? mirr : ofs;
        cos_idx = quad[0] ? ofs  : mirr;
        sin_neg = quad[1];
        cos_neg = quad[1] ^ quad[0];
    end
endmodule

// File: rtl/quarter_wave_rom.sv
module quarter_wave_rom
    import aspect_pkg::*;
(
    input  qidx_t idx,
    output mag_t  mag
);
    always_comb begin
        unique case (idx)
            5'd0:    mag = 8'd0;
            5'd1:    mag = 8'd13;
            5'd2:    mag = 8'd25;
            5'd3:    mag = 8'd37;
            5'd4:    mag = 8'd49;
            5'd5:    mag = 8'd60;
            5'd6:    mag = 8'd71;
            5'd7:    mag = 8'd81;
            5'd8:    mag = 8'd91;
            5'd9:    mag = 8'd99;
            5'd10:   mag = 8'd106;
            5'd11:   mag = 8'd113;
            5'd12:   mag = 8'd118;
            5'd13:   mag = 8'd122;
            5'd14:   mag = 8'd126;
            5'd15:   mag = 8'd127;
            5'd16:   mag = 8'd128;
            default: mag = 8'd0;
        endcase
    end
endmodule

// File: rtl/stepped_aspect_gen.sv
module stepped_aspect_gen
    import aspect_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic [5:0] step_num,
    input  logic       restart,
    input  logic       advance,
    output logic [5:0] phase_o,
    output logic [7:0] cos_mag_o,
    output logic       cos_neg_o,
    output logic [7:0] sin_mag_o,
    output logic       sin_neg_o
);
    logic   emit;
    phase_t cur_phase;
    qidx_t  s_idx, c_idx;
    logic   s_neg, c_neg;
    mag_t   s_mag, c_mag;

    sweep_phase_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .restart(restart), .advance(advance),
        .step_num(step_num), .emit(emit), .cur_phase(cur_phase)
    );

    quadrant_fold u_fold (
        .phase(cur_phase), .sin_idx(s_idx), .cos_idx(c_idx),
        .sin_neg(s_neg), .cos_neg(c_neg)
    );

    quarter_wave_rom u_sin_rom (.idx(s_idx), .mag(s_mag));
    quarter_wave_rom u_cos_rom (.idx(c_idx), .mag(c_mag));

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_o   <= '0;
            cos_mag_o <= '0;
            cos_neg_o <= 1'b0;
            sin_mag_o <= '0;
            sin_neg_o <= 1'b0;
        end else if (emit) begin
            phase_o   <= cur_phase;
            cos_mag_o <= c_mag;
            cos_neg_o <= c_neg;
            sin_mag_o <= s_mag;
            sin_neg_o <= s_neg;
        end
    end

    assert_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
        !advance |=> ($stable(phase_o) && $stable(cos_mag_o) && $stable(sin_mag_o)
                      && $stable(cos_neg_o) && $stable(sin_neg_o)));
    assert_mag_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (cos_mag_o <= 8'(UNITY)) && (sin_mag_o <= 8'(UNITY)));
    assert_axis_exact_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_o[4:0] == 5'd0 && cos_mag_o != 8'd0) |-> (cos_mag_o == 8'(UNITY) && sin_mag_o == 8'd0));
    assert_restart_emit_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (restart && advance) |=> (phase_o == 6'd0 && cos_mag_o == 8'(UNITY)));
endmodule

// File: tb/stepped_aspect_gen_tb.sv
module stepped_aspect_gen_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [5:0] step_num = '0;
    logic       restart = 1'b0;
    logic       advance = 1'b0;
    logic [5:0] phase_o;
    logic [7:0] cos_mag_o, sin_mag_o;
    logic       cos_neg_o, sin_neg_o;

    int checks = 0;
    int fails  = 0;
    int cyc    = 0;

    // reference model state
    bit      m_started = 0;
    int      m_acc = 0, m_step = 0;
    int      e_ph = 0, e_cm = 0, e_sm = 0, e_cn = 0, e_sn = 0;

    stepped_aspect_gen u_dut (
        .clk(clk), .rst_n(rst_n), .step_num(step_num), .restart(restart),
        .advance(advance), .phase_o(phase_o), .cos_mag_o(cos_mag_o),
        .cos_neg_o(cos_neg_o), .sin_mag_o(sin_mag_o), .sin_neg_o(sin_neg_o)
    );

    always #5 clk = ~clk;

    task automatic report();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL R3 watchdog expired act=%0d exp=<150000", cyc);
            report();
        end
    end

    function automatic int ref_mag(int p, bit is_cos);
        real a, v;
        a = 2.0 * 3.14159265358979 * p / 64.0;
        v = is_cos ? $cos(a) : $sin(a);
        if (v < 0.0) v = -v;
        return $rtoi(v * 128.0 + 0.5);
    endfunction

    function automatic int ref_cneg(int p);
        return ((p / 16) == 1 || (p / 16) == 2) ? 1 : 0;
    endfunction

    function automatic int ref_sneg(int p);
        return ((p / 16) >= 2) ? 1 : 0;
    endfunction

    task automatic chk(string tag, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s act=%0d exp=%0d", tag, what, act, exp);
        end
    endtask

    // drive at falling edge, model at rising edge, compare at next falling edge
    task automatic cycle(bit r, bit a, int s, string tag);
        bit emitted;
        restart  = r;
        advance  = a;
        step_num = 6'(s);
        @(posedge clk);
        emitted = 0;
        if (r) begin
            m_acc = 0; m_step = s; m_started = 1;
        end
        if (a && m_started) begin
            e_ph = m_acc;
            e_cm = ref_mag(m_acc, 1);
            e_sm = ref_mag(m_acc, 0);
            e_cn = ref_cneg(m_acc);
            e_sn = ref_sneg(m_acc);
            m_acc = (m_acc + m_step) % 64;
            emitted = 1;
        end
        @(negedge clk);
        if (emitted) begin
            chk(tag,  "phase",   int'(phase_o),   e_ph);
            chk("R7", "cos_mag", int'(cos_mag_o), e_cm);
            chk("R6", "sin_mag", int'(sin_mag_o), e_sm);
            chk("R8", "cos_neg", int'(cos_neg_o), e_cn);
            chk("R8", "sin_neg", int'(sin_neg_o), e_sn);
            chk("R10", "mag_bound", int'(cos_mag_o > 128 || sin_mag_o > 128), 0);
        end else begin
            chk(m_started ? "R5" : "R4", "held_out",
                int'({phase_o, cos_mag_o, cos_neg_o, sin_mag_o, sin_neg_o}),
                int'({6'(e_ph), 8'(e_cm), 1'(e_cn), 8'(e_sm), 1'(e_sn)}));
        end
    endtask

    initial begin
        void'($urandom(32'd20240611));
        @(negedge clk);
        @(negedge clk);
        // R1: reset state
        chk("R1", "reset_out",
            int'({phase_o, cos_mag_o, cos_neg_o, sin_mag_o, sin_neg_o}), 0);
        rst_n = 1'b1;

        // R4: advances before any restart are ignored
        for (int i = 0; i < 3; i++) cycle(0, 1, 9, "R4");

        // R2/R3/R6/R7/R8/R10: step 1 covers every phase of the circle
        cycle(1, 0, 1, "R2");
        for (int i = 0; i < 64; i++) cycle(0, 1, 1, i == 0 ? "R2" : "R3");
        cycle(0, 0, 1, "R5");

        // R9: step 0 always phase 0, step 32 alternates 0 and 32
        cycle(1, 0, 0, "R9");
        for (int i = 0; i < 3; i++) cycle(0, 1, 0, "R9");
        cycle(1, 0, 32, "R9");
        for (int i = 0; i < 4; i++) cycle(0, 1, 32, "R9");
        chk("R9", "cos_at_32", int'({cos_neg_o, cos_mag_o, sin_mag_o}), int'({1'b1, 8'd128, 8'd0}));

        // R11: restart and advance on the same cycle
        cycle(1, 1, 21, "R11");
        cycle(0, 1, 21, "R11");
        cycle(0, 1, 21, "R11");

        // R12: restart mid-sweep with a new step
        cycle(0, 1, 7, "R12");
        cycle(1, 0, 7, "R12");
        for (int i = 0; i < 5; i++) cycle(0, 1, 7, "R12");

        // random sweeps
        for (int sw = 0; sw < 60; sw++) begin
            int s, len;
            s   = int'($urandom_range(0, 63));
            len = int'($urandom_range(1, 80));
            cycle(1, ($urandom_range(0, 3) == 0), s, "R11");
            for (int k = 0; k < len; k++)
                cycle(0, ($urandom_range(0, 3) != 0), int'($urandom_range(0, 63)), "R3");
        end
        report();
    end
endmodule